// File: doc/BRIEF.md
# Region-Based Address Translator

This block widens a 32-bit processor address into a 36-bit system address. Eight remapping regions are each configured with an enable, a power-of-two size, a base within the 32-bit space, a replacement value for the low 32 output bits and a 4-bit field that supplies the top output bits. Each incoming address is compared against every enabled region. When a region claims the address, the block sends out the region's replacement address with the offset inside the region kept. When no region claims it, the address leaves unchanged with zeros in the top four bits.

Software or a boot sequencer loads the regions through a simple write port: a strobe, a region index, a register selector and a 32-bit data word. The translation path is one register stage by default. A parameter gives a purely combinational variant. A hit flag and the index of the winning region come out beside the address so that a bench or a neighbour can see which region decided the result.

Top module: `region_addr_xlat`

## Requirements
- R1: After reset every region is disabled. Every address then leaves zero-extended, and the hit flag and the region index are both 0.
- R2: On a hit, the output is {upper field, (lower & ~M) | (addr & M)}, where M is the region's offset mask. The hit flag is 1 and the region index names the region. Example: with base 0x8000_0000, lower 0x0, upper 0x4 and a size of 512 MB, address 0x8000_0000 gives 0x4_0000_0000.
- R3: The control register keeps the enable in bit 0 and the size code (log2 of the byte count) in bits 13:8. A code below 12 acts as 12 (4 KB). A code above 32 acts as 32, which covers the whole 32-bit space.
- R4: An address that no enabled region claims leaves as {4'h0, addr}, with the hit flag at 0 and the region index at 0.
- R5: An address matches when its bits at and above the size code equal the base's bits there. Base bits below the size are ignored, and so are lower-field bits below the size. Example: with base 0xC000_0000, size 1 GB, upper 0x9 and lower 0x0, address 0xFFFF_FFFF gives 0x9_3FFF_FFFF.
- R6: A region whose enable bit is 0 never matches, whatever its base and translated fields hold.
- R7: When several enabled regions match, the lowest-numbered one decides the output and the index.
- R8: In the default registered variant, an address sampled at one rising edge shows its result right after that edge. A configuration write at one edge governs translations sampled at the next edge.
- R9: Register selector encoding: 0 is control, 1 is base, 2 is the lower field and 3 is the upper field (data bits 3:0). A write changes only the selected register of the indexed region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 3 | Region index for the write |
| cfg_sel | input | 2 | Register selector for the write |
| cfg_wdata | input | 32 | Write data |
| in_addr | input | 32 | Processor address |
| out_addr | output | 36 | Translated system address |
| out_hit | output | 1 | An enabled region claimed the address |
| out_region | output | 3 | Index of the winning region (0 on a miss) |

## Verification
A translated address, its hit flag and its region index are all due one rising edge after the input address is applied. A configuration write is due to affect the address sampled on the edge after the write edge. The bench applies every input at a falling edge and compares outputs at the next falling edge, so exactly one rising edge lies between stimulus and check. It issues a check immediately after a write, which tests that the write takes effect on the very next translation.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_BASE  = 2'd1,
      SEL_LOWER = 2'd2,
      SEL_UPPER = 2'd3
   } xlat_sel_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_SIZE_LSB = 8;
   localparam int CTRL_SIZE_W   = 6;
   localparam int MIN_LOG2      = 12;
endpackage

// File: rtl/xlat_region.sv
module xlat_region
   import xlat_pkg::*;
#(
   parameter int IN_W  = 32,
   parameter int OUT_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [IN_W-1:0]  wr_data,
   input  logic [IN_W-1:0]  addr_i,
   output logic             match_o,
   output logic [OUT_W-1:0] xlat_o
);
   localparam int UP_W = OUT_W - IN_W;

   logic                   en_q;
   logic [CTRL_SIZE_W-1:0] size_q;
   logic [IN_W-1:0]        base_q;
   logic [IN_W-1:0]        lower_q;
   logic [UP_W-1:0]        upper_q;
   logic [CTRL_SIZE_W-1:0] lg;
   logic [IN_W:0]          span;
   logic [IN_W-1:0]        mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         size_q  <= '0;
         base_q  <= '0;
         lower_q <= '0;
         upper_q <= '0;
      end else if (wr_en) begin
         case (xlat_sel_e'(wr_sel))
            SEL_CTRL: begin
               en_q   <= wr_data[CTRL_EN_BIT];
               size_q <= wr_data[CTRL_SIZE_LSB +: CTRL_SIZE_W];
            end
            SEL_BASE:  base_q  <= wr_data;
            SEL_LOWER: lower_q <= wr_data;
            default:   upper_q <= wr_data[UP_W-1:0];
         endcase
      end
   end

   always_comb begin
      if (size_q < CTRL_SIZE_W'(MIN_LOG2))   lg = CTRL_SIZE_W'(MIN_LOG2);
      else if (size_q > CTRL_SIZE_W'(IN_W)) lg = CTRL_SIZE_W'(IN_W);
      else                                   lg = size_q;
      span = (IN_W+1)'(1) << lg;
      mask = span[IN_W-1:0] - IN_W'(1);
   end

   assign match_o = en_q && ((addr_i & ~mask) == (base_q & ~mask));
   assign xlat_o  = {upper_q, (lower_q & ~mask) | (addr_i & mask)};

   p_disable_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_CTRL && !wr_data[CTRL_EN_BIT]) |=> !match_o);
endmodule

// File: rtl/xlat_prio.sv
module xlat_prio #(
   parameter int N     = 8,
   parameter int OUT_W = 36
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         match_i,
   input  logic [OUT_W-1:0]     xlat_i [N],
   output logic                 hit_o,
   output logic [$clog2(N)-1:0] idx_o,
   output logic [OUT_W-1:0]     xlat_o
);
   localparam int IDX_W = $clog2(N);

   always_comb begin
      hit_o  = 1'b0;
      idx_o  = '0;
      xlat_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match_i[i]) begin
            hit_o  = 1'b1;
            idx_o  = IDX_W'(i);
            xlat_o = xlat_i[i];
         end
      end
   end

   p_idx_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> match_i[idx_o]);
   p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ((match_i & ((N'(1) << idx_o) - N'(1))) == '0));
   p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_i == '0) |-> (!hit_o && idx_o == '0));
endmodule

// File: rtl/region_addr_xlat.sv
module region_addr_xlat
   import xlat_pkg::*;
#(
   parameter int IN_W    = 32,
   parameter int OUT_W   = 36,
   parameter int REGIONS = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [$clog2(REGIONS)-1:0] cfg_region,
   input  logic [1:0]                 cfg_sel,
   input  logic [IN_W-1:0]            cfg_wdata,
   input  logic [IN_W-1:0]            in_addr,
   output logic [OUT_W-1:0]           out_addr,
   output logic                       out_hit,
   output logic [$clog2(REGIONS)-1:0] out_region
);
   localparam int IDX_W = $clog2(REGIONS);
   localparam int UP_W  = OUT_W - IN_W;

   if (UP_W < 1)
      $error("OUT_W must exceed IN_W");
   if (IN_W < MIN_LOG2 || IN_W > (1 << CTRL_SIZE_W) - 1)
      $error("IN_W out of range for the size field");
   if (REGIONS < 2 || (1 << IDX_W) != REGIONS)
      $error("REGIONS must be a power of two of at least 2");

   logic [REGIONS-1:0] match;
   logic [OUT_W-1:0]   xlat [REGIONS];
   logic               sel_hit;
   logic [IDX_W-1:0]   sel_idx;
   logic [OUT_W-1:0]   sel_addr;
   logic [OUT_W-1:0]   nxt_addr;

   for (genvar g = 0; g < REGIONS; g++) begin : g_region
      xlat_region #(.IN_W(IN_W), .OUT_W(OUT_W)) u_region (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_we && cfg_region == IDX_W'(g)),
         .wr_sel  (cfg_sel),
         .wr_data (cfg_wdata),
         .addr_i  (in_addr),
         .match_o (match[g]),
         .xlat_o  (xlat[g])
      );
   end

   xlat_prio #(.N(REGIONS), .OUT_W(OUT_W)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .match_i (match),
      .xlat_i  (xlat),
      .hit_o   (sel_hit),
      .idx_o   (sel_idx),
      .xlat_o  (sel_addr)
   );

   assign nxt_addr = sel_hit ? sel_addr : {UP_W'(0), in_addr};

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_addr   <= '0;
            out_hit    <= 1'b0;
            out_region <= '0;
         end else begin
            out_addr   <= nxt_addr;
            out_hit    <= sel_hit;
            out_region <= sel_idx;
         end
      end

      p_miss_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (out_hit || out_addr == {UP_W'(0), $past(in_addr)}));
      p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (!out_hit || out_addr[MIN_LOG2-1:0] == $past(in_addr[MIN_LOG2-1:0])));
      p_idx_zero_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !out_hit |-> out_region == '0);
   end else begin : g_comb
      assign out_addr   = nxt_addr;
      assign out_hit    = sel_hit;
      assign out_region = sel_idx;
   end
endmodule

// File: tb/region_addr_xlat_tb_top.sv
module region_addr_xlat_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_region = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] in_addr = '0;
   logic [35:0] out_addr;
   logic        out_hit;
   logic [2:0]  out_region;

   int errors = 0;
   int checks = 0;

   logic        m_en  [8];
   logic [5:0]  m_sz  [8];
   logic [31:0] m_base[8];
   logic [31:0] m_low [8];
   logic [3:0]  m_up  [8];

   always #4 clk = ~clk;

   region_addr_xlat dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .in_addr(in_addr),
      .out_addr(out_addr), .out_hit(out_hit), .out_region(out_region)
   );

   function automatic logic [31:0] f_mask(input logic [5:0] code);
      int l;
      logic [63:0] s;
      l = (code < 12) ? 12 : (code > 32) ? 32 : int'(code);
      s = (64'd1 << l) - 64'd1;
      return s[31:0];
   endfunction

   function automatic logic [39:0] f_expect(input logic [31:0] a);
      logic [31:0] m;
      for (int i = 0; i < 8; i++) begin
         m = f_mask(m_sz[i]);
         if (m_en[i] && ((a & ~m) == (m_base[i] & ~m)))
            return {i[2:0], 1'b1, m_up[i], (m_low[i] & ~m) | (a & m)};
      end
      return {3'd0, 1'b0, 4'h0, a};
   endfunction

   task automatic wr(input int r, input int s, input logic [31:0] d);
      cfg_we = 1'b1; cfg_region = r[2:0]; cfg_sel = s[1:0]; cfg_wdata = d;
      case (s)
         0: begin m_en[r] = d[0]; m_sz[r] = d[13:8]; end
         1: m_base[r] = d;
         2: m_low[r]  = d;
         default: m_up[r] = d[3:0];
      endcase
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input int r, input bit en, input int code,
                        input logic [31:0] b, input logic [31:0] lo, input logic [3:0] up);
      wr(r, 1, b);
      wr(r, 2, lo);
      wr(r, 3, {28'h0, up});
      wr(r, 0, {18'h0, 6'(code), 7'h0, en});
   endtask

   task automatic chk(input string tag, input logic [31:0] a);
      logic [39:0] e;
      in_addr = a;
      e = f_expect(a);
      @(negedge clk);
      checks++;
      if ({out_region, out_hit, out_addr} !== e) begin
         errors++;
         $display("FAIL %s addr=%h actual region=%0d hit=%0b out=%h expected region=%0d hit=%0b out=%h",
                  tag, a, out_region, out_hit, out_addr, e[39:37], e[36], e[35:0]);
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_en[i] = 0; m_sz[i] = 0; m_base[i] = 0; m_low[i] = 0; m_up[i] = 0;
      end
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      checks++;
      if (out_addr !== '0 || out_hit !== 1'b0 || out_region !== '0) begin
         errors++;
         $display("FAIL R1 reset outputs actual %h/%0b/%0d expected 0/0/0", out_addr, out_hit, out_region);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pass-through after reset", 32'h1234_5678);
      chk("R1 top address after reset", 32'hFFFF_FFFF);

      // R8: check issued right after the write
      setup(0, 1, 29, 32'h8000_0000, 32'h0, 4'h4);
      chk("R2 R8 region0 start", 32'h8000_0000);
      setup(1, 1, 29, 32'hA000_0000, 32'h8000_0000, 4'h0);
      setup(2, 1, 30, 32'hC000_0000, 32'h0, 4'h9);
      chk("R5 region2 last byte", 32'hFFFF_FFFF);
      chk("R2 region1 middle", 32'hA123_4567);
      chk("R4 below regions", 32'h7FFF_FFFF);
      chk("R2 region0 end", 32'h9FFF_FFFF);

      // R9: upper write of region 1 leaves region 0 alone
      wr(1, 3, 32'hFFFF_FFF7);
      chk("R9 region1 upper", 32'hA000_0010);
      chk("R9 region0 unchanged", 32'h8000_0010);

      // R5: unaligned base and lower ignored below size
      setup(3, 1, 16, 32'h0005_ABCD, 32'h1234_FFFF, 4'h2);
      chk("R5 unaligned base", 32'h0005_0042);
      chk("R4 next block misses", 32'h0006_0042);

      // R7: region 6 overlaps region 3 with a larger span
      setup(6, 1, 20, 32'h0000_0000, 32'h5550_0000, 4'h7);
      chk("R7 lower index wins", 32'h0005_1111);
      chk("R7 only region6", 32'h0007_2222);

      // R6: disabled region with populated fields
      wr(3, 0, {18'h0, 6'd16, 8'h00});
      chk("R6 disabled region3", 32'h0005_1111);
      wr(6, 0, 32'h0);
      chk("R6 disabled region6", 32'h0007_2222);

      // R3: clamp codes
      setup(5, 1, 3, 32'h4000_1000, 32'h0, 4'h1);
      chk("R3 small code acts as 4KB", 32'h4000_1FFF);
      chk("R3 small code miss", 32'h4000_2000);
      setup(4, 1, 40, 32'h0, 32'h0, 4'hE);
      chk("R3 large code covers all", 32'h3333_3333);
      wr(4, 0, 32'h0);
      chk("R6 region4 off", 32'h3333_3333);

      for (int n = 0; n < 300; n++) begin
         if (n % 15 == 0) begin
            int r;
            r = $urandom_range(0, 7);
            setup(r, ($urandom_range(0, 3) != 0), $urandom_range(10, 34),
                  $urandom, $urandom, 4'($urandom));
         end
         begin
            int r;
            logic [31:0] a, m;
            r = $urandom_range(0, 7);
            m = f_mask(m_sz[r]);
            a = $urandom;
            if ($urandom_range(0, 1) == 1) a = (m_base[r] & ~m) | (a & m);
            chk("R2 R7 random", a);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule